// File: doc/BRIEF.md
# Masked Prefix Popcount Generator

This block turns a bit vector into a row of running counts. For each element position it reports how many source bits are set and active at the positions strictly below it. The count is an exclusive cumulative popcount. A predicate mask controls which bits count and which destination lanes are written. Either operand can be marked absent. An absent value or mask is read as all ones. With both absent, the block produces the index sequence 0, 1, 2 and so on.

A caller supplies the value word, the mask word, a flag for each saying whether it is present, the active length, and the previous destination contents. It then pulses the start strobe. One cycle later the packed result holds a count in every active lane, zero-extended to the element width. Lanes that the predicate disables, and lanes at or past the active length, carry their previous contents through unchanged. A one-cycle done pulse marks the update.

Top module: `iota_gen`

## Requirements
- R1: For a lane i below the active length whose effective mask bit is 1, the result is the number of positions j < i where both the effective value bit and the effective mask bit are 1. Lane i occupies bits [i*ELEM_W +: ELEM_W] of the packed buses, and bit i of the value and mask words belongs to lane i.
- R2: When `val_en_i` is 0, the value word is treated as all ones. With the mask absent as well, lane i then reads i for every lane below the active length.
- R3: When `mask_en_i` is 0, the mask word is treated as all ones, so every lane below the active length is written and every value bit takes part.
- R4: When `mask_en_i` is 1, a lane whose mask bit is 0 takes its value from `old_i`, and its value bit adds nothing to any count.
- R5: Lanes at index `vl_i` or above take their value from `old_i`. A `vl_i` above LANES is treated as LANES, and a `vl_i` of 0 leaves every lane at its old value.
- R6: The result and `done_o` update on the first rising clock edge after `start_i` is sampled high. `done_o` is high for exactly that one cycle. Without `start_i`, the result holds its value.
- R7: While `rst_n` is low, `res_o` is all zeros and `done_o` is 0.
- R8: A written count occupies the low $clog2(LANES)+1 bits of its lane, and the upper bits are 0. A written lane 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to compute and register a result |
| val_i | input | LANES | Source bit vector, bit i for lane i |
| val_en_i | input | 1 | 1: use `val_i`; 0: value is all ones |
| mask_i | input | LANES | Predicate mask, bit i for lane i |
| mask_en_i | input | 1 | 1: use `mask_i`; 0: mask is all ones |
| vl_i | input | $clog2(LANES+1) | Active length in lanes |
| old_i | input | LANES*ELEM_W | Previous destination contents, packed by lane |
| res_o | output | LANES*ELEM_W | Registered result, packed by lane |
| done_o | output | 1 | One-cycle pulse when a new result is in `res_o` |

## Verification
The properties assume that `val_i`, `mask_i`, their present flags, `vl_i` and `old_i` are stable during the cycle in which `start_i` is sampled. They also assume that `start_i` is a clean synchronous level, never X after reset. The bench changes every input on the falling edge and raises `start_i` for exactly one cycle per operation. Between operations it moves the other inputs with the strobe low, which exercises the hold behaviour without breaking those assumptions.

// File: rtl/iota_pkg.sv
package iota_pkg;

    // Source picked for one destination lane
    typedef enum logic {
        LANE_KEEP  = 1'b0,
        LANE_COUNT = 1'b1
    } lane_src_e;

endpackage

// File: rtl/iota_prefix_count.sv
module iota_prefix_count #(
    parameter int LANES = 8,
    parameter int CNT_W = $clog2(LANES) + 1
) (
    input  logic [LANES-1:0]            bits_i,
    output logic [LANES-1:0][CNT_W-1:0] cnt_o
);

    // Exclusive running sum: lane i sees only bits below i
    assign cnt_o[0] = '0;

    for (genvar i = 1; i < LANES; i++) begin : g_chain
        assign cnt_o[i] = cnt_o[i-1] + CNT_W'(bits_i[i-1]);
    end

endmodule

// File: rtl/iota_lane_select.sv
module iota_lane_select
    import iota_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ELEM_W = 16,
    parameter int CNT_W  = $clog2(LANES) + 1,
    parameter int VL_W   = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]             pred_i,
    input  logic [VL_W-1:0]              vl_i,
    input  logic [LANES-1:0][CNT_W-1:0]  cnt_i,
    input  logic [LANES-1:0][ELEM_W-1:0] old_i,
    output logic [LANES-1:0][ELEM_W-1:0] lane_o
);

    localparam int PAD_W = ELEM_W - CNT_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_src_e src;

        always_comb begin
            src = LANE_KEEP;
            if ((VL_W'(i) < vl_i) && pred_i[i]) begin
                src = LANE_COUNT;
            end
        end

        always_comb begin
            unique case (src)
                LANE_COUNT: lane_o[i] = {{PAD_W{1'b0}}, cnt_i[i]};
                default:    lane_o[i] = old_i[i];
            endcase
        end
    end

endmodule

// File: rtl/iota_gen.sv
module iota_gen #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 16,
    parameter int VL_W   = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [LANES-1:0]        val_i,
    input  logic                    val_en_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic                    mask_en_i,
    input  logic [VL_W-1:0]         vl_i,
    input  logic [LANES*ELEM_W-1:0] old_i,
    output logic [LANES*ELEM_W-1:0] res_o,
    output logic                    done_o
);

    localparam int CNT_W = $clog2(LANES) + 1;
    localparam logic [VL_W-1:0] VL_MAX = VL_W'(LANES);

    typedef struct packed {
        logic [LANES-1:0][ELEM_W-1:0] res;
        logic                         done;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]             val_eff;
    logic [LANES-1:0]             mask_eff;
    logic [LANES-1:0]             live_bits;
    logic [VL_W-1:0]              vl_eff;
    logic [LANES-1:0][CNT_W-1:0]  cnt;
    logic [LANES-1:0][ELEM_W-1:0] old_lanes;
    logic [LANES-1:0][ELEM_W-1:0] merged;

    always_comb begin
        val_eff   = val_en_i  ? val_i  : '1;
        mask_eff  = mask_en_i ? mask_i : '1;
        live_bits = val_eff & mask_eff;
        vl_eff    = (vl_i > VL_MAX) ? VL_MAX : vl_i;
        old_lanes = old_i;
    end

    iota_prefix_count #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_count (
        .bits_i (live_bits),
        .cnt_o  (cnt)
    );

    iota_lane_select #(
        .LANES  (LANES),
        .ELEM_W (ELEM_W),
        .CNT_W  (CNT_W),
        .VL_W   (VL_W)
    ) u_select (
        .pred_i (mask_eff),
        .vl_i   (vl_eff),
        .cnt_i  (cnt),
        .old_i  (old_lanes),
        .lane_o (merged)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.res  = merged;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o  = st_q.res;
    assign done_o = st_q.done;

endmodule

// File: rtl/iota_gen_chk.sv
module iota_gen_chk #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 16,
    parameter int VL_W   = $clog2(LANES + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [LANES-1:0]        mask_i,
    input logic                    mask_en_i,
    input logic [VL_W-1:0]         vl_i,
    input logic [LANES*ELEM_W-1:0] old_i,
    input logic [LANES*ELEM_W-1:0] res_o,
    input logic                    done_o
);

    assert_done_follows_start_R6: assert property (
        @(posedge clk) disable iff (!rst_n) start_i |=> done_o);

    assert_hold_when_idle_R6: assert property (
        @(posedge clk) disable iff (!rst_n) !start_i |=> (!done_o && $stable(res_o)));

    assert_lane0_zero_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (start_i && vl_i != '0 && (!mask_en_i || mask_i[0]))
        |=> res_o[ELEM_W-1:0] == '0);

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        assert_count_bound_R1: assert property (
            @(posedge clk) disable iff (!rst_n)
            (start_i && VL_W'(i) < vl_i && (!mask_en_i || mask_i[i]))
            |=> res_o[i*ELEM_W +: ELEM_W] <= ELEM_W'(i));

        assert_masked_keep_R4: assert property (
            @(posedge clk) disable iff (!rst_n)
            (start_i && VL_W'(i) < vl_i && mask_en_i && !mask_i[i])
            |=> res_o[i*ELEM_W +: ELEM_W] == $past(old_i[i*ELEM_W +: ELEM_W]));

        assert_tail_keep_R5: assert property (
            @(posedge clk) disable iff (!rst_n)
            (start_i && vl_i <= VL_W'(i))
            |=> res_o[i*ELEM_W +: ELEM_W] == $past(old_i[i*ELEM_W +: ELEM_W]));
    end

endmodule

bind iota_gen iota_gen_chk #(
    .LANES  (LANES),
    .ELEM_W (ELEM_W),
    .VL_W   (VL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mask_i    (mask_i),
    .mask_en_i (mask_en_i),
    .vl_i      (vl_i),
    .old_i     (old_i),
    .res_o     (res_o),
    .done_o    (done_o)
);

// File: tb/iota_gen_tb.sv
`timescale 1ns/1ps
module iota_gen_tb;

    localparam int LANES  = 8;
    localparam int ELEM_W = 16;
    localparam int VL_W   = $clog2(LANES + 1);
    localparam int BUS_W  = LANES * ELEM_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LANES-1:0] val_i = '0;
    logic             val_en_i = 1'b1;
    logic [LANES-1:0] mask_i = '0;
    logic             mask_en_i = 1'b0;
    logic [VL_W-1:0]  vl_i = '0;
    logic [BUS_W-1:0] old_i = '0;
    logic [BUS_W-1:0] res_o;
    logic             done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    iota_gen #(.LANES(LANES), .ELEM_W(ELEM_W), .VL_W(VL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .val_i(val_i), .val_en_i(val_en_i),
        .mask_i(mask_i), .mask_en_i(mask_en_i),
        .vl_i(vl_i), .old_i(old_i),
        .res_o(res_o), .done_o(done_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference built from the requirement text
    function automatic logic [BUS_W-1:0] model(
        input logic [LANES-1:0] v, input logic ve,
        input logic [LANES-1:0] m, input logic me,
        input int vl, input logic [BUS_W-1:0] old);
        logic [BUS_W-1:0] r;
        logic [LANES-1:0] ev, em;
        int lim, c;
        r   = old;
        ev  = ve ? v : '1;
        em  = me ? m : '1;
        lim = (vl > LANES) ? LANES : vl;
        for (int i = 0; i < lim; i++) begin
            if (em[i]) begin
                c = 0;
                for (int j = 0; j < i; j++) if (ev[j] && em[j]) c++;
                r[i*ELEM_W +: ELEM_W] = ELEM_W'(c);
            end
        end
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] old_seq(input int base);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*ELEM_W +: ELEM_W] = ELEM_W'(base + i);
        return r;
    endfunction

    // Drive one operation, then compare lanes and the done pulse
    task automatic run_op(input string tag,
                          input logic [LANES-1:0] v, input logic ve,
                          input logic [LANES-1:0] m, input logic me,
                          input int vl, input logic [BUS_W-1:0] old);
        logic [BUS_W-1:0] exp;
        exp = model(v, ve, m, me, vl, old);
        @(negedge clk);
        val_i = v; val_en_i = ve; mask_i = m; mask_en_i = me;
        vl_i = VL_W'(vl); old_i = old; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(tag, "done pulse", 64'(done_o), 64'd1);
        for (int i = 0; i < LANES; i++)
            check(tag, $sformatf("lane %0d", i),
                  64'(res_o[i*ELEM_W +: ELEM_W]), 64'(exp[i*ELEM_W +: ELEM_W]));
        @(negedge clk);
        check(tag, "done drops", 64'(done_o), 64'd0);
    endtask

    task automatic t_reset;
        check("R7", "res at reset", 64'(res_o != '0), 64'd0);
        check("R7", "done at reset", 64'(done_o), 64'd0);
    endtask

    task automatic t_unmasked_example;
        logic [BUS_W-1:0] exp;
        // R1: source 10010001 -> lanes 7..0 = 2,2,2,1,1,1,1,0
        run_op("R1", 8'b1001_0001, 1'b1, '0, 1'b0, 8, old_seq(100));
        exp = '0;
        exp[0*16 +: 16] = 0; exp[1*16 +: 16] = 1; exp[2*16 +: 16] = 1;
        exp[3*16 +: 16] = 1; exp[4*16 +: 16] = 1; exp[5*16 +: 16] = 2;
        exp[6*16 +: 16] = 2; exp[7*16 +: 16] = 2;
        check("R1", "worked example", 64'(res_o == exp), 64'd1);
    endtask

    task automatic t_masked_example;
        logic [BUS_W-1:0] old, exp;
        // R4: mask 11101011, old lanes 7..0 = 2..9 -> 1,1,1,5,1,7,1,0
        for (int i = 0; i < LANES; i++) old[i*16 +: 16] = 16'(9 - i);
        run_op("R4", 8'b1001_0001, 1'b1, 8'b1110_1011, 1'b1, 8, old);
        exp = '0;
        exp[0*16 +: 16] = 0; exp[1*16 +: 16] = 1; exp[2*16 +: 16] = 7;
        exp[3*16 +: 16] = 1; exp[4*16 +: 16] = 5; exp[5*16 +: 16] = 1;
        exp[6*16 +: 16] = 1; exp[7*16 +: 16] = 1;
        check("R4", "worked example", 64'(res_o == exp), 64'd1);
    endtask

    task automatic t_index_sequence;
        // R2 and R3: both operands absent gives 0..VL-1
        run_op("R2", 8'h5A, 1'b0, 8'h0F, 1'b0, 8, old_seq(50));
        for (int i = 0; i < LANES; i++)
            check("R2", "index lane", 64'(res_o[i*16 +: 16]), 64'(i));
    endtask

    task automatic t_mask_only;
        // R3 vs R2: value absent, mask present counts active mask bits below
        run_op("R2", 8'h00, 1'b0, 8'b0110_1101, 1'b1, 8, old_seq(30));
        // R3: mask absent, value counts across every lane
        run_op("R3", 8'b1111_0110, 1'b1, 8'h00, 1'b0, 8, old_seq(40));
    endtask

    task automatic t_length;
        // R5: partial length, zero length, oversize length
        run_op("R5", 8'hFF, 1'b1, 8'hFF, 1'b1, 5, old_seq(200));
        for (int i = 5; i < LANES; i++)
            check("R5", "tail keeps old", 64'(res_o[i*16 +: 16]), 64'(200 + i));
        run_op("R5", 8'hFF, 1'b0, 8'h00, 1'b0, 0, old_seq(300));
        run_op("R5", 8'hC3, 1'b1, 8'hFF, 1'b0, 9, old_seq(400));
        run_op("R5", 8'hAA, 1'b1, 8'h77, 1'b1, 15, old_seq(500));
    endtask

    task automatic t_hold;
        logic [BUS_W-1:0] snap;
        // R6: no strobe means no change even when inputs move
        snap = res_o;
        @(negedge clk);
        val_i = 8'h3C; mask_i = 8'hF0; mask_en_i = 1'b1; vl_i = 4'd3;
        old_i = old_seq(900);
        repeat (3) @(negedge clk);
        check("R6", "result held", 64'(res_o == snap), 64'd1);
        check("R6", "done idle", 64'(done_o), 64'd0);
    endtask

    task automatic t_width;
        // R8: upper lane bits zero on a full count
        run_op("R8", 8'hFF, 1'b1, 8'hFF, 1'b1, 8, {LANES{16'hFFFF}});
        for (int i = 0; i < LANES; i++)
            check("R8", "upper bits", 64'(res_o[i*16+4 +: 12]), 64'd0);
    endtask

    task automatic t_back_to_back;
        logic [BUS_W-1:0] e1, e2;
        // R6: two strobes in adjacent cycles each land one cycle later
        e1 = model(8'h0F, 1'b1, 8'hFF, 1'b0, 8, old_seq(10));
        e2 = model(8'hF0, 1'b1, 8'hFF, 1'b0, 8, old_seq(10));
        @(negedge clk);
        val_i = 8'h0F; val_en_i = 1'b1; mask_en_i = 1'b0; vl_i = 4'd8;
        old_i = old_seq(10); start_i = 1'b1;
        @(negedge clk);
        check("R6", "first result", 64'(res_o == e1), 64'd1);
        val_i = 8'hF0;
        @(negedge clk);
        start_i = 1'b0;
        check("R6", "second result", 64'(res_o == e2), 64'd1);
        check("R6", "done still high", 64'(done_o), 64'd1);
        @(negedge clk);
        check("R6", "done low", 64'(done_o), 64'd0);
    endtask

    initial begin : watchdog
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unmasked_example();
        t_masked_example();
        t_index_sequence();
        t_mask_only();
        t_length();
        t_hold();
        t_width();
        t_back_to_back();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule